// File: doc/BRIEF.md
# Hardwired Eight-Phase Accumulator Core

This block is a compact 16-bit processor built around one accumulator register, G, and a hardwired control unit. Every instruction passes through eight clock phases. The first three phases fetch the word that the program counter points at, step the counter, and latch the word into an instruction register. The remaining five phases carry out the decoded operation. One-hot decode lines are combined with the phase number to pick the single source that drives an internal shared bus, and to pick the registers that capture from it.

Program and data share a word-addressed memory array inside the block. While the core is held in reset or has halted, a preload port writes words into that array. A separate combinational read port lets the environment inspect memory at any time. A typical use is to hold reset, load a program and its data, and release reset. The core then runs from address 0 until it executes a halt, and its results are read back through the read port and the G output.

Top module: `acc_core`

## Requirements
- R1: Each executed instruction takes exactly 8 clock cycles. If the halt instruction is the n-th instruction executed (counting from 0) after reset is released, `halted` rises right after the (8n+4)-th rising edge.
- R2: A synchronous reset (`rst` high) clears the program counter, G and the phase counter, and sets the core running. During reset, `halted` is 0 and `g_out` is 0. Execution begins at address 0 once reset drops.
- R3: An instruction word carries its opcode in bits 15:12 and an address operand in bits 11:0. Load-G (opcode 0x6) copies the memory word at the operand address into G. The copy shows on `g_out` right after the fifth edge of that instruction.
- R4: Store-G (opcode 0x7) writes G into memory at the operand address.
- R5: Add (opcode 0x1) sets G to the sum, modulo 2^16, of G and the memory word at the operand address. No carry is kept. The new G shows right after the eighth edge of the instruction.
- R6: Jump (opcode 0xA) continues execution at the operand address.
- R7: Jump-if-negative (opcode 0x9) continues at the operand address when bit 15 of G is 1. Otherwise execution continues at the next address.
- R8: Halt (opcode 0x0) stops the core. `halted` then stays 1, and G, memory and the program counter stay unchanged until the next reset.
- R9: A preload write (`ld_en` high) takes effect at a clock edge only while `rst` is high or `halted` is 1. While the core is running the write is ignored.
- R10: No-op (opcode 0xF) changes neither G nor memory and falls through to the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write strobe |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word |
| rd_addr | input | 12 | Inspection read address |
| rd_data | output | 16 | Memory word at `rd_addr`, combinational |
| halted | output | 1 | High once the core has stopped |
| g_out | output | 16 | Current value of the accumulator G |

## Verification
The bench targets a jump-if-negative that must not branch on a positive G and must branch on a negative one. A wrong test on bit 15 would land on a halt placed at the branch target or skip the tail of the program, and the halt-cycle count and stored results would both be wrong. Two additions that overflow 16 bits test the wrap: a design that kept a carry or widened the sum would leave a non-zero G. The bench samples the edge just before and the edge at which G changes for load and add, which catches a phase that is off by one. It also writes to the preload port in mid-run, which an unguarded write path would accept and leave a changed word in memory.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   // opcode values (bits 15:12 of an instruction word)
   localparam int OPC_HLT = 4'h0;
   localparam int OPC_ADD = 4'h1;
   localparam int OPC_LDG = 4'h6;
   localparam int OPC_SDG = 4'h7;
   localparam int OPC_JMI = 4'h9;
   localparam int OPC_JMP = 4'hA;
   localparam int OPC_NOP = 4'hF;

   // strobes produced by the hardwired control for one phase
   typedef struct packed {
      logic pc_out;   // program counter onto bus
      logic opr_out;  // zero-extended operand onto bus
      logic mem_out;  // memory word at MAR onto bus
      logic g_out;    // accumulator onto bus
      logic sum_out;  // adder result onto bus
      logic mar_ld;
      logic mbr_ld;
      logic ir_ld;
      logic pc_inc;
      logic pc_ld;
      logic g_ld;
      logic mem_wr;
      logic a_ld;
      logic b_ld;
      logic sum_ld;
      logic stop;
   } ctl_t;

endpackage

// File: rtl/acc_phase_gen.sv
module acc_phase_gen #(
   parameter int NUM_SC = 8,
   localparam int SC_W = $clog2(NUM_SC)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stop,
   output logic            run,
   output logic [SC_W-1:0] sc
);

   localparam logic [SC_W-1:0] SC_LAST = SC_W'(NUM_SC - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         run <= 1'b1;
         sc  <= '0;
      end else if (run) begin
         sc  <= (sc == SC_LAST) ? '0 : sc + 1'b1;
         if (stop) run <= 1'b0;
      end
   end

endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inc,
   input  logic              ld,
   input  logic [ADDR_W-1:0] bus_in,
   output logic [ADDR_W-1:0] pc
);

   logic [ADDR_W-1:0] pc_plus1;
   logic [ADDR_W-1:0] pc_nxt;

   assign pc_plus1 = pc + 1'b1;
   assign pc_nxt   = ld ? bus_in : pc_plus1;

   always_ff @(posedge clk) begin
      if (rst)             pc <= '0;
      else if (ld || inc)  pc <= pc_nxt;
   end

endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);

   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cell_q[waddr] <= wdata;
   end

   assign rdata_a = cell_q[raddr_a];
   assign rdata_b = cell_q[raddr_b];

endmodule

// File: rtl/acc_ctl.sv
module acc_ctl
   import acc_core_pkg::*;
#(
   parameter int NUM_SC = 8,
   parameter int OPC_W  = 4,
   localparam int SC_W  = $clog2(NUM_SC),
   localparam int NDEC  = 1 << OPC_W
) (
   input  logic             active,
   input  logic [SC_W-1:0]  sc,
   input  logic [OPC_W-1:0] opc,
   input  logic             g_neg,
   output ctl_t             ctl
);

   localparam logic [NDEC-1:0] KNOWN_MASK =
      NDEC'((1 << OPC_HLT) | (1 << OPC_ADD) | (1 << OPC_LDG) | (1 << OPC_SDG) |
            (1 << OPC_JMI) | (1 << OPC_JMP) | (1 << OPC_NOP));

   logic [NDEC-1:0] dec;
   logic [7:0]      ph;
   logic            exec_ok;

   // one-hot opcode decoder
   for (genvar i = 0; i < NDEC; i++) begin : g_dec
      assign dec[i] = (opc == OPC_W'(i));
   end

   // one-hot phase strobes
   for (genvar p = 0; p < 8; p++) begin : g_ph
      assign ph[p] = active && (sc == SC_W'(p));
   end

   // undefined codes fall through as if they were no-ops
   assign exec_ok = ~|(dec & ~KNOWN_MASK);

   logic d_hlt, d_add, d_ldg, d_sdg, d_jmi, d_jmp, jump_go;
   assign d_hlt   = exec_ok && dec[OPC_HLT];
   assign d_add   = exec_ok && dec[OPC_ADD];
   assign d_ldg   = exec_ok && dec[OPC_LDG];
   assign d_sdg   = exec_ok && dec[OPC_SDG];
   assign d_jmi   = exec_ok && dec[OPC_JMI];
   assign d_jmp   = exec_ok && dec[OPC_JMP];
   assign jump_go = d_jmp || (d_jmi && g_neg);

   always_comb begin
      ctl = '0;
      // fetch
      ctl.pc_out  = ph[0];
      ctl.mar_ld  = ph[0] || (ph[3] && (d_ldg || d_sdg || d_add));
      ctl.mbr_ld  = ph[1];
      ctl.pc_inc  = ph[1];
      ctl.ir_ld   = ph[2];
      // execute
      ctl.opr_out = ph[3] && (d_ldg || d_sdg || d_add || jump_go);
      ctl.pc_ld   = ph[3] && jump_go;
      ctl.stop    = ph[3] && d_hlt;
      ctl.mem_out = ph[4] && (d_ldg || d_add);
      ctl.g_out   = (ph[4] && d_sdg) || (ph[5] && d_add);
      ctl.mem_wr  = ph[4] && d_sdg;
      ctl.a_ld    = ph[4] && d_add;
      ctl.b_ld    = ph[5] && d_add;
      ctl.sum_ld  = ph[6] && d_add;
      ctl.sum_out = ph[7] && d_add;
      ctl.g_ld    = (ph[4] && d_ldg) || (ph[7] && d_add);
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int OPC_W  = 4,
   parameter int NUM_SC = 8,
   localparam int SC_W  = $clog2(NUM_SC)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              halted,
   output logic [DATA_W-1:0] g_out
);

   if (DATA_W != ADDR_W + OPC_W) begin : g_bad_split
      $error("acc_core: DATA_W must equal ADDR_W + OPC_W");
   end
   if (NUM_SC < 8) begin : g_bad_sc
      $error("acc_core: NUM_SC must be at least 8");
   end
   if (OPC_W != 4) begin : g_bad_opc
      $error("acc_core: opcode field must be 4 bits wide");
   end

   ctl_t              ctl;
   logic              run_q;
   logic [SC_W-1:0]   sc_q;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [DATA_W-1:0] mbr_q, ir_q, g_q, a_q, b_q, sum_q;
   logic [DATA_W-1:0] bus, mem_word;
   logic [4:0]        drv_vec;
   logic              pre_ok, mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] opr_ext, pc_ext;

   acc_phase_gen #(.NUM_SC(NUM_SC)) u_phase (
      .clk(clk), .rst(rst), .stop(ctl.stop), .run(run_q), .sc(sc_q)
   );

   acc_ctl #(.NUM_SC(NUM_SC), .OPC_W(OPC_W)) u_ctl (
      .active(run_q && !rst),
      .sc(sc_q),
      .opc(ir_q[DATA_W-1 -: OPC_W]),
      .g_neg(g_q[DATA_W-1]),
      .ctl(ctl)
   );

   acc_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk(clk), .rst(rst), .inc(ctl.pc_inc), .ld(ctl.pc_ld),
      .bus_in(bus[ADDR_W-1:0]), .pc(pc_q)
   );

   // preload only when stopped or held in reset
   assign pre_ok    = ld_en && (rst || !run_q);
   assign mem_we    = ctl.mem_wr || pre_ok;
   assign mem_waddr = ctl.mem_wr ? mar_q : ld_addr;
   assign mem_wdata = ctl.mem_wr ? bus   : ld_data;

   acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr_a(mar_q), .rdata_a(mem_word),
      .raddr_b(rd_addr), .rdata_b(rd_data)
   );

   // shared bus: AND-OR of the enabled source
   assign opr_ext = {{(DATA_W-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
   assign pc_ext  = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
   assign drv_vec = {ctl.pc_out, ctl.opr_out, ctl.mem_out, ctl.g_out, ctl.sum_out};
   assign bus = ({DATA_W{ctl.pc_out}}  & pc_ext)   |
                ({DATA_W{ctl.opr_out}} & opr_ext)  |
                ({DATA_W{ctl.mem_out}} & mem_word) |
                ({DATA_W{ctl.g_out}}   & g_q)      |
                ({DATA_W{ctl.sum_out}} & sum_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         g_q <= '0;
      end else if (ctl.g_ld) begin
         g_q <= bus;
      end
   end

   always_ff @(posedge clk) begin
      if (ctl.mar_ld) mar_q <= bus[ADDR_W-1:0];
      if (ctl.mbr_ld) mbr_q <= mem_word;
      if (ctl.ir_ld)  ir_q  <= mbr_q;
      if (ctl.a_ld)   a_q   <= bus;
      if (ctl.b_ld)   b_q   <= bus;
      if (ctl.sum_ld) sum_q <= a_q + b_q;
   end

   assign halted = !run_q;
   assign g_out  = g_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int OPC_W  = 4,
   parameter int NUM_SC = 8,
   localparam int SC_W  = $clog2(NUM_SC)
) (
   input logic              clk,
   input logic              rst,
   input logic              run,
   input logic [SC_W-1:0]   sc,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] g,
   input logic [OPC_W-1:0]  opc,
   input logic [4:0]        drv
);

   localparam logic [SC_W-1:0] SC_LAST = SC_W'(NUM_SC - 1);

   // R1: phase counter steps by one (wrapping) each running cycle
   assert_sc_step_R1: assert property (@(posedge clk) disable iff (rst)
      run |=> sc == (($past(sc) == SC_LAST) ? '0 : $past(sc) + 1'b1));

   // R1: at most one source drives the shared bus
   assert_bus_single_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(drv));

   // R8: once stopped, the core stays stopped and its phase frozen
   assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
      !run |=> !run && $stable(sc) && $stable(g) && $stable(pc));

   // R6: program counter only moves in the fetch-step or jump phase
   assert_pc_window_R6: assert property (@(posedge clk) disable iff (rst)
      (sc != SC_W'(1) && sc != SC_W'(3)) |=> $stable(pc));

   // R5: accumulator only changes in the load or add write-back phase
   assert_g_window_R5: assert property (@(posedge clk) disable iff (rst)
      (sc != SC_W'(4) && sc != SC_W'(7)) |=> $stable(g));

   // R7: jump-if-negative with non-negative G leaves the counter alone
   assert_jmi_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (run && sc == SC_W'(3) && opc == OPC_W'(9) && !g[DATA_W-1]) |=> $stable(pc));

endmodule

bind acc_core acc_core_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W), .NUM_SC(NUM_SC)
) u_chk (
   .clk(clk), .rst(rst), .run(run_q), .sc(sc_q), .pc(pc_q), .g(g_q),
   .opc(ir_q[DATA_W-1 -: OPC_W]), .drv(drv_vec)
);

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic [11:0] ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic [11:0] rd_addr = '0;
   logic [15:0] rd_data;
   logic        halted;
   logic [15:0] g_out;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   acc_core u_dut (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .halted(halted), .g_out(g_out)
   );

   // expected items: 0 = final G, 1 = edges to halt, 2 = memory word
   typedef struct {
      int          kind;
      logic [11:0] addr;
      logic [15:0] val;
      string       req;
   } exp_t;

   exp_t        sbq[$];
   logic [15:0] ref_mem [4096];
   int          edge_cnt = 0;
   bit          mon_done = 1'b1;

   always @(posedge clk) begin
      if (rst) edge_cnt <= 0;
      else if (!halted) edge_cnt <= edge_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_up();
   end

   task automatic put(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = d;
      ref_mem[a] = d;
   endtask

   task automatic put_end();
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // instruction-level model of the requirements; queues expected items
   task automatic model_and_push(input string req_g, input logic [11:0] addrs[$]);
      logic [11:0] pc = '0;
      logic [15:0] g  = '0;
      int          n  = 0;
      bit          stop = 1'b0;
      exp_t        it;
      for (int i = 0; i < 500 && !stop; i++) begin
         logic [15:0] w;
         logic [11:0] opr;
         w   = ref_mem[pc];
         opr = w[11:0];
         pc  = pc + 12'd1;
         n++;
         case (w[15:12])
            4'h0: stop = 1'b1;
            4'h1: g = g + ref_mem[opr];
            4'h6: g = ref_mem[opr];
            4'h7: ref_mem[opr] = g;
            4'h9: if (g[15]) pc = opr;
            4'hA: pc = opr;
            default: ;
         endcase
      end
      it.kind = 0; it.addr = '0; it.val = g; it.req = req_g;
      sbq.push_back(it);
      it.kind = 1; it.val = 16'(8 * (n - 1) + 4); it.req = "R1";
      sbq.push_back(it);
      foreach (addrs[k]) begin
         it.kind = 2; it.addr = addrs[k]; it.val = ref_mem[addrs[k]]; it.req = "R4";
         sbq.push_back(it);
      end
   endtask

   // monitor: on halt, pop every expected item and compare
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && halted === 1'b1 && !mon_done) begin
            while (sbq.size() > 0) begin
               exp_t it;
               it = sbq.pop_front();
               case (it.kind)
                  0: chk(g_out == it.val, it.req, "final G", g_out, it.val);
                  1: chk(edge_cnt == int'(it.val), it.req, "edges until halt",
                         edge_cnt, it.val);
                  default: begin
                     rd_addr = it.addr;
                     #1;
                     chk(rd_data == it.val, it.req, "stored word", rd_data, it.val);
                  end
               endcase
            end
            mon_done = 1'b1;
         end
      end
   end

   initial begin
      logic [15:0] g_hold;
      logic [11:0] a1[$];
      logic [11:0] a2[$];

      // ---------- reset state (R2) ----------
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(halted == 1'b0, "R2", "halted in reset", halted, 0);
      chk(g_out == 16'h0, "R2", "G in reset", g_out, 0);

      // ---------- program 1: branches, wrap, jump, no-op ----------
      // preload while in reset (R9)
      put(12'h000, 16'h6020);   // ldg 20
      put(12'h001, 16'h9010);   // jmi 10  (G positive: not taken, R7)
      put(12'h002, 16'h1021);   // add 21  -> 0x8003
      put(12'h003, 16'h7030);   // sdg 30
      put(12'h004, 16'h9008);   // jmi 8   (G negative: taken, R7)
      put(12'h005, 16'h0000);   // hlt (must be skipped)
      put(12'h008, 16'hA00B);   // jmp B (R6)
      put(12'h009, 16'h0000);   // hlt (must be skipped)
      put(12'h00A, 16'h0000);
      put(12'h00B, 16'hF000);   // nop (R10)
      put(12'h00C, 16'h1022);   // add 22 -> wraps to 0x0003 (R5)
      put(12'h00D, 16'h7031);   // sdg 31
      put(12'h00E, 16'h0000);   // hlt
      put(12'h010, 16'h0000);   // hlt at wrong branch target
      put(12'h020, 16'h0005);
      put(12'h021, 16'h7FFE);
      put(12'h022, 16'h8000);
      put(12'h030, 16'h0000);
      put(12'h031, 16'h0000);
      put_end();
      a1.push_back(12'h030);
      a1.push_back(12'h031);
      model_and_push("R5 R7 R10", a1);
      mon_done = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      wait (mon_done);

      // halt holds state (R8)
      g_hold = g_out;
      repeat (20) @(negedge clk);
      chk(halted == 1'b1, "R8", "halted holds", halted, 1);
      chk(g_out == g_hold, "R8", "G frozen after halt", g_out, g_hold);
      rd_addr = 12'h031;
      #1;
      chk(rd_data == 16'h0003, "R8", "memory frozen after halt", rd_data, 16'h0003);

      // ---------- program 2: timing of load/add, preload guard ----------
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(g_out == 16'h0, "R2", "reset clears G", g_out, 0);
      chk(halted == 1'b0, "R2", "reset restarts core", halted, 0);
      put(12'h000, 16'h6040);   // ldg 40
      put(12'h001, 16'h1041);   // add 41
      put(12'h002, 16'h7042);   // sdg 42
      put(12'h003, 16'h0000);   // hlt
      put(12'h040, 16'hFFFF);
      put(12'h041, 16'h0001);
      put(12'h042, 16'h1111);
      put(12'h050, 16'h0000);
      put_end();
      a2.push_back(12'h042);
      model_and_push("R5", a2);
      mon_done = 1'b0;
      @(negedge clk);
      rst = 1'b0;

      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(g_out == 16'h0000, "R3", "G before load phase", g_out, 0);
      @(posedge clk);
      @(negedge clk);
      chk(g_out == 16'hFFFF, "R3", "G after load phase", g_out, 16'hFFFF);
      // preload attempt while running (R9): must be ignored
      ld_en = 1'b1; ld_addr = 12'h050; ld_data = 16'hBEEF;
      @(negedge clk);
      ld_en = 1'b0;
      repeat (9) @(posedge clk);
      @(negedge clk);
      chk(g_out == 16'hFFFF, "R5", "G before add write-back", g_out, 16'hFFFF);
      @(posedge clk);
      @(negedge clk);
      chk(g_out == 16'h0000, "R5", "G after wrapping add", g_out, 0);
      wait (mon_done);

      rd_addr = 12'h050;
      #1;
      chk(rd_data == 16'h0000, "R9", "write during run ignored", rd_data, 0);

      // preload accepted while halted (R9)
      put(12'h060, 16'hA5A5);
      put_end();
      rd_addr = 12'h060;
      #1;
      chk(rd_data == 16'hA5A5, "R9", "write while halted", rd_data, 16'hA5A5);

      finish_up();
   end

endmodule